// File: doc/BRIEF.md
# I2C Byte-Handshake Bus Master

This block drives an I2C bus as its only master and moves one byte per software handshake. Software sees four 8-bit registers. It loads an address byte and launches a START by writing a master mode and the start/stop bit into the status register. After each byte and its acknowledge clock, the block raises a pending flag and holds SCL low. It stays stalled until software clears that flag. Clearing the flag releases the next byte, a repeated START or a STOP, depending on what software has asked for.

The bit rate comes from a selectable coarse prescale followed by a 4-bit divisor. In receive mode the acknowledge bit is driven from a control bit, so software ends a read by turning acknowledge off before the last byte. Both bus lines are open-drain: the block only reports when it pulls a line low, and it reads SDA back.

Top module: `i2c_byte_master`

## Requirements
- R1: With prescale select (control bit 6) clear, one SCL period lasts PRE_LO*(divisor+1) clock cycles. With it set, the period lasts PRE_HI*(divisor+1) cycles. The divisor is control bits [3:0]. SCL is high for half of each period.
- R2: Register offsets are 0 control, 1 status, 2 own address, 3 data. Control bit 4 is the pending flag. Software can clear it by writing 0 but cannot set it by writing 1. irq_o is high only while pending and interrupt enable (control bit 5) are both set.
- R3: Writing status with bits 7, 5 and 4 set while the bus is free launches a START. The data register content is then sent MSB first. Status bit 5 reads 1 (busy) from the START onward. Status bits [7:6] hold the mode: 11 transmit, 10 receive.
- R4: After the ninth clock of every byte, pending is set and SCL is held low. No further clock edge appears until pending is cleared.
- R5: Status bit 0 holds the SDA level sampled on the ninth clock of the last transmitted byte (1 = NACK).
- R6: In receive mode the received byte is placed in the data register. On the ninth clock the block pulls SDA low if control bit 7 is set and leaves it released otherwise.
- R7: A status write with bit 5 clear during a transfer, followed by clearing pending, produces a STOP (SDA rising while SCL is high). Busy reads 0 only after the STOP, with both lines released.
- R8: A status write with bit 5 set during a transfer, followed by clearing pending, produces a repeated START with no STOP in between, then sends the data register as the address byte.
- R9: SCL and SDA never change in the same clock cycle. SDA moves while SCL is high only to form a START or a STOP.
- R10: A data-register write while busy with pending clear is ignored. Writes are accepted while the bus is free or pending is set.
- R11: The own-address register holds and reads back the last value written.
- R12: After reset all registers read 0 and both lines are released. Both lines stay released whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the register at addr_i |
| irq_o | output | 1 | Interrupt request |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The bench builds the block with PRE_LO=4 and PRE_HI=8 rather than the default 16 and 512. It uses divisors of 1 and 2, so a full byte takes tens of cycles. Both prescale paths can therefore be timed edge to edge, and a run can cover write, NACK, repeated-START read and STOP sequences. A behavioural slave and bus monitor decode every START, STOP, bit and acknowledge on each clock. They also flag any cycle in which both lines move.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_OWN  = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BIT, S_HOLD, S_STOP, S_TAIL, S_RSTART
  } eng_st_e;

  typedef struct packed {
    logic       ack_en;
    logic       pre_hi;
    logic       irq_en;
    logic       pend;
    logic [3:0] div;
  } ctrl_t;
endpackage

// File: rtl/i2cm_clkgen.sv
module i2cm_clkgen #(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 512,
  parameter int unsigned DIV_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             pre_hi_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  // one tick per quarter SCL period
  localparam int unsigned Q_LO = PRE_LO / 4;
  localparam int unsigned Q_HI = PRE_HI / 4;
  localparam int unsigned PW   = $clog2(Q_HI + 1);

  logic [PW-1:0]    pcnt_q, plim;
  logic [DIV_W-1:0] dcnt_q;
  logic             pwrap, dwrap;

  assign plim   = pre_hi_i ? PW'(Q_HI - 1) : PW'(Q_LO - 1);
  assign pwrap  = (pcnt_q >= plim);
  assign dwrap  = (dcnt_q >= div_i);
  assign tick_o = pwrap && dwrap && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else if (clr_i) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else if (pwrap) begin
      pcnt_q <= '0;
      dcnt_q <= dwrap ? '0 : dcnt_q + 1'b1;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              pend_i,
  input  logic              stop_req_i,
  input  logic              rstart_req_i,
  input  logic              tx_mode_i,
  input  logic              ack_en_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              sda_i,
  output logic              scl_lo_o,
  output logic              sda_lo_o,
  output logic              busy_o,
  output logic              byte_done_o,
  output logic              byte_tx_o,
  output logic              ack_smp_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              take_o
);
  localparam int unsigned BW = $clog2(BYTE_W + 1);
  localparam logic [BW-1:0] ACK_SLOT = BW'(BYTE_W);

  eng_st_e           st_q;
  logic [1:0]        ph_q;
  logic [BW-1:0]     bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              tx_q, scl_q, sda_q, busy_q;

  assign take_o      = (st_q == S_HOLD) && !pend_i;
  assign byte_done_o = tick_i && (st_q == S_BIT) && (ph_q == 2'd3) && (bit_q == ACK_SLOT);
  assign byte_tx_o   = tx_q;
  assign ack_smp_o   = sda_i;
  assign rx_byte_o   = sh_q;
  assign scl_lo_o    = scl_q;
  assign sda_lo_o    = sda_q;
  assign busy_o      = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ph_q   <= 2'd0;
      bit_q  <= '0;
      sh_q   <= '0;
      tx_q   <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start_i) begin
            st_q   <= S_START;
            ph_q   <= 2'd0;
            busy_q <= 1'b1;
          end
        end
        S_HOLD: begin
          if (!pend_i) begin
            ph_q <= 2'd0;
            if (rstart_req_i)    st_q <= S_RSTART;
            else if (stop_req_i) st_q <= S_STOP;
            else begin
              st_q  <= S_BIT;
              bit_q <= '0;
              sh_q  <= data_i;
              tx_q  <= tx_mode_i;
            end
          end
        end
        default: begin
          if (tick_i) begin
            ph_q <= ph_q + 2'd1;
            case (st_q)
              S_START: begin
                if (ph_q == 2'd1) sda_q <= 1'b1;
                if (ph_q == 2'd3) begin
                  scl_q <= 1'b1;
                  st_q  <= S_BIT;
                  bit_q <= '0;
                  sh_q  <= data_i;
                  tx_q  <= 1'b1;   // address byte always goes out
                end
              end
              S_BIT: begin
                if (ph_q == 2'd0)
                  sda_q <= (bit_q == ACK_SLOT) ? (!tx_q && ack_en_i) : (tx_q && !sh_q[BYTE_W-1]);
                if (ph_q == 2'd1) scl_q <= 1'b0;
                if (ph_q == 2'd3) begin
                  scl_q <= 1'b1;
                  if (bit_q == ACK_SLOT) st_q <= S_HOLD;
                  else begin
                    bit_q <= bit_q + 1'b1;
                    sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
                  end
                end
              end
              S_STOP: begin
                if (ph_q == 2'd0) sda_q <= 1'b1;
                if (ph_q == 2'd1) scl_q <= 1'b0;
                if (ph_q == 2'd3) begin
                  sda_q <= 1'b0;
                  st_q  <= S_TAIL;
                end
              end
              S_TAIL: begin
                if (ph_q == 2'd1) begin
                  st_q   <= S_IDLE;
                  ph_q   <= 2'd0;
                  busy_q <= 1'b0;
                end
              end
              S_RSTART: begin
                if (ph_q == 2'd0) sda_q <= 1'b0;
                if (ph_q == 2'd1) scl_q <= 1'b0;
                if (ph_q == 2'd3) st_q  <= S_START;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  input  logic       sda_i
);
  ctrl_t       ctrl_q;
  logic [1:0]  mode_q;
  logic        txe_q, nack_q, stop_req_q, rstart_req_q;
  logic [7:0]  own_q, data_q;
  logic        wr_ctrl, wr_stat, wr_own, wr_data, start_cmd;
  logic        tick, busy, byte_done, byte_tx, ack_smp, take, scl_lo, sda_lo;
  logic [7:0]  rx_byte;

  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_stat   = wr_en_i && (addr_i == A_STAT);
  assign wr_own    = wr_en_i && (addr_i == A_OWN);
  assign wr_data   = wr_en_i && (addr_i == A_DATA);
  assign start_cmd = wr_stat && !busy && wdata_i[7] && wdata_i[5] && wdata_i[4];

  i2cm_clkgen #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(4)) u_clk (
    .clk_i, .rst_ni,
    .clr_i    (start_cmd || take),
    .pre_hi_i (ctrl_q.pre_hi),
    .div_i    (ctrl_q.div),
    .tick_o   (tick)
  );

  i2cm_engine u_eng (
    .clk_i, .rst_ni,
    .tick_i       (tick),
    .start_i      (start_cmd),
    .pend_i       (ctrl_q.pend),
    .stop_req_i   (stop_req_q),
    .rstart_req_i (rstart_req_q),
    .tx_mode_i    (mode_q[0]),
    .ack_en_i     (ctrl_q.ack_en),
    .data_i       (data_q),
    .sda_i        (sda_i),
    .scl_lo_o     (scl_lo),
    .sda_lo_o     (sda_lo),
    .busy_o       (busy),
    .byte_done_o  (byte_done),
    .byte_tx_o    (byte_tx),
    .ack_smp_o    (ack_smp),
    .rx_byte_o    (rx_byte),
    .take_o       (take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q       <= '0;
      mode_q       <= 2'b00;
      txe_q        <= 1'b0;
      nack_q       <= 1'b0;
      stop_req_q   <= 1'b0;
      rstart_req_q <= 1'b0;
      own_q        <= '0;
      data_q       <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.div    <= wdata_i[3:0];
        ctrl_q.irq_en <= wdata_i[5];
        ctrl_q.pre_hi <= wdata_i[6];
        ctrl_q.ack_en <= wdata_i[7];
      end
      if (byte_done)                 ctrl_q.pend <= 1'b1;
      else if (wr_ctrl && !wdata_i[4]) ctrl_q.pend <= 1'b0;

      if (take) begin
        stop_req_q   <= 1'b0;
        rstart_req_q <= 1'b0;
      end
      if (wr_stat) begin
        mode_q <= wdata_i[7:6];
        txe_q  <= wdata_i[4];
        if (busy) begin
          if (wdata_i[5]) rstart_req_q <= 1'b1;
          else            stop_req_q   <= 1'b1;
        end
      end

      if (byte_done && byte_tx) nack_q <= ack_smp;
      if (wr_own) own_q <= wdata_i;

      if (byte_done && !byte_tx)                 data_q <= rx_byte;
      else if (wr_data && (!busy || ctrl_q.pend)) data_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_STAT:  rdata_o = {mode_q, busy, txe_q, 3'b000, nack_q};
      A_OWN:   rdata_o = own_q;
      default: rdata_o = data_q;
    endcase
  end

  assign irq_o    = ctrl_q.pend && ctrl_q.irq_en;
  assign scl_oe_o = scl_lo;
  assign sda_oe_o = sda_lo;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_oe_i,
  input logic       sda_oe_i,
  input logic       irq_i,
  input logic       pend_i,
  input logic       busy_i,
  input logic       byte_done_i,
  input logic       wr_en_i,
  input logic [1:0] addr_i,
  input logic [7:0] data_i
);
  assert_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |-> scl_oe_i);

  assert_byte_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |-> !pend_i);

  assert_irq_pend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> pend_i);

  assert_no_twin_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(scl_oe_i) || $stable(sda_oe_i));

  assert_idle_lines_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!scl_oe_i && !sda_oe_i));

  assert_stop_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(!sda_oe_i && !scl_oe_i));

  assert_data_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd3 && busy_i && !pend_i && !byte_done_i) |=> $stable(data_i));
endmodule

bind i2c_byte_master i2cm_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_oe_i    (scl_oe_o),
  .sda_oe_i    (sda_oe_o),
  .irq_i       (irq_o),
  .pend_i      (ctrl_q.pend),
  .busy_i      (busy),
  .byte_done_i (byte_done),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .data_i      (data_q)
);

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  localparam int PRE_LO = 4;
  localparam int PRE_HI = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, scl_oe, sda_oe;
  logic       sl_pull = 1'b0;
  logic       scl_line, sda_line;

  always #4 clk = ~clk;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || sl_pull);

  i2c_byte_master #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural bus monitor and slave at address 0x50
  int         cyc = 0;
  logic       p_scl = 1'b1, p_sda = 1'b1;
  int         bitc = 0, byte_idx = 0;
  logic [7:0] cur = 8'h00, txb = 8'hFF;
  logic       rw = 1'b0, stx_active = 1'b0, nack_next = 1'b0;
  logic [7:0] rdq[$];
  logic [8:0] log_q[$];
  int         n_start = 0, n_stop = 0;
  int         last_rise = 0, last_per = 0, last_hi = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic s, d;
      cyc++;
      s = scl_line;
      d = sda_line;
      checks++;
      if (s != p_scl && d != p_sda) begin
        fails++;
        $display("FAIL R9 both lines moved at cycle %0d actual=1 expected=0", cyc);
      end
      if (s && p_scl && p_sda && !d) begin
        n_start++; bitc = 0; byte_idx = 0; rw = 1'b0; stx_active = 1'b0;
      end
      if (s && p_scl && !p_sda && d) begin
        n_stop++; bitc = 0; stx_active = 1'b0;
      end
      if (s && !p_scl) begin
        if (bitc >= 1 && bitc <= 8) last_per = cyc - last_rise;
        last_rise = cyc;
        if (bitc < 8) begin
          cur = {cur[6:0], d};
          bitc++;
        end else begin
          log_q.push_back({cur, d});
          if (byte_idx == 0) begin
            rw = cur[0];
            stx_active = cur[0] && (cur[7:1] == 7'h50);
          end else if (rw && d) begin
            stx_active = 1'b0;
          end
          byte_idx++;
          bitc = 0;
        end
      end
      if (!s && p_scl) begin
        last_hi = cyc - last_rise;
        if (bitc == 8) begin
          if (byte_idx == 0) sl_pull = (cur[7:1] == 7'h50);
          else if (!rw) begin sl_pull = !nack_next; nack_next = 1'b0; end
          else sl_pull = 1'b0;
        end else if (rw && stx_active && byte_idx >= 1) begin
          if (bitc == 0) txb = (rdq.size() > 0) ? rdq.pop_front() : 8'hFF;
          sl_pull = !txb[7-bitc];
        end else begin
          sl_pull = 1'b0;
        end
      end
      p_scl = s;
      p_sda = d;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] dv);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = dv;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] dv);
    @(negedge clk);
    addr = a;
    #1 dv = rdata;
  endtask

  task automatic wait_pend(input string req);
    int n = 0;
    @(negedge clk);
    addr = 2'd0;
    #1;
    while (!rdata[4] && n < 5000) begin
      @(negedge clk); #1; n++;
    end
    chk(req, rdata[4], 1);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    @(negedge clk);
    addr = 2'd1;
    #1;
    while (rdata[5] && n < 5000) begin
      @(negedge clk); #1; n++;
    end
    chk(req, rdata[5], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    rd(2'd0, v); chk("R12 ctrl reset", v, 8'h00);
    rd(2'd1, v); chk("R12 status reset", v, 8'h00);
    rd(2'd3, v); chk("R12 data reset", v, 8'h00);
    chk("R12 scl released", scl_oe, 0);
    chk("R12 sda released", sda_oe, 0);
    chk("R2 irq at reset", irq, 0);
    // R11 own address
    wr(2'd2, 8'h5A);
    rd(2'd2, v); chk("R11 own address", v, 8'h5A);

    // write transfer, divisor 1, small prescale
    wr(2'd0, 8'hA1);
    wr(2'd3, 8'hA0);
    wr(2'd1, 8'hF0);
    rd(2'd1, v); chk("R3 status after start", v, 8'hF0);
    wait_pend("R4 pending after address");
    chk("R3 one START", n_start, 1);
    chk("R3 address byte", log_q.size() > 0 ? int'(log_q[0]) : -1, {8'hA0, 1'b0});
    chk("R2 irq with enable", irq, 1);
    chk("R1 period low prescale", last_per, PRE_LO * 2);
    chk("R1 high time low prescale", last_hi, PRE_LO);
    rd(2'd1, v); chk("R5 ack on address", v[0], 0);
    repeat (40) @(negedge clk);
    chk("R4 scl held low", scl_oe, 1);
    chk("R4 no clock while pending", log_q.size(), 1);
    wr(2'd0, 8'hB1);
    rd(2'd0, v); chk("R2 writing 1 keeps pending", v, 8'hB1);

    wr(2'd3, 8'h3C);
    wr(2'd0, 8'hA1);
    repeat (6) @(negedge clk);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R10 data write ignored mid byte", v, 8'h3C);
    wait_pend("R4 pending after data");
    chk("R4 data byte sent", log_q.size() > 1 ? int'(log_q[1]) : -1, {8'h3C, 1'b0});

    nack_next = 1'b1;
    wr(2'd3, 8'h77);
    wr(2'd0, 8'hA1);
    wait_pend("R4 pending after nacked byte");
    chk("R5 nacked byte on bus", log_q.size() > 2 ? int'(log_q[2]) : -1, {8'h77, 1'b1});
    rd(2'd1, v); chk("R5 nack flag", v[0], 1);

    wr(2'd1, 8'hD0);
    wr(2'd0, 8'hA1);
    wait_idle("R7 busy clears");
    chk("R7 one STOP", n_stop, 1);
    chk("R7 scl released", scl_oe, 0);
    chk("R7 sda released", sda_oe, 0);

    // register read with repeated start
    rdq.push_back(8'hC3);
    rdq.push_back(8'h5E);
    wr(2'd3, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend("R4 pending read address");
    wr(2'd3, 8'h01);
    wr(2'd0, 8'hA1);
    wait_pend("R4 pending index");
    wr(2'd3, 8'hA1);
    wr(2'd1, 8'hB0);
    wr(2'd0, 8'hA1);
    wait_pend("R8 pending after repeated start");
    chk("R8 second START seen", n_start, 3);
    chk("R8 no STOP before restart", n_stop, 1);
    chk("R8 read address", log_q.size() > 5 ? int'(log_q[5]) : -1, {8'hA1, 1'b0});
    wr(2'd0, 8'hA1);
    wait_pend("R6 pending first rx");
    rd(2'd3, v); chk("R6 first rx byte", v, 8'hC3);
    chk("R6 master ack", log_q.size() > 6 ? int'(log_q[6]) : -1, {8'hC3, 1'b0});
    wr(2'd0, 8'h21);
    wait_pend("R6 pending last rx");
    rd(2'd3, v); chk("R6 last rx byte", v, 8'h5E);
    chk("R6 master nack", log_q.size() > 7 ? int'(log_q[7]) : -1, {8'h5E, 1'b1});
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h21);
    wait_idle("R7 busy clears after read");
    chk("R7 STOP after read", n_stop, 2);

    // large prescale, divisor 2, interrupt disabled
    wr(2'd0, 8'h42);
    wr(2'd3, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend("R4 pending big prescale");
    chk("R1 period high prescale", last_per, PRE_HI * 3);
    chk("R1 high time high prescale", last_hi, PRE_HI * 3 / 2);
    chk("R2 irq masked", irq, 0);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h42);
    wait_idle("R7 final stop");
    chk("R7 STOP count", n_stop, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule